// File: doc/BRIEF.md
# Edge-Event Channel Transmitter with Level Refresh

This block is the sending half of a single isolated data channel, written as synchronous logic. A one-bit input is first passed through a synchroniser. Each rising or falling transition that it then detects becomes a one-cycle symbol on a two-bit link toward the far side, and the symbol code tells which way the transition went. When the line is static, nothing is sent, so the far side keeps the last level it was given.

To stop the receiver from drifting when the line stays static for a long time, each channel has a refresh enable that turns on an inactivity watchdog. The first level-refresh symbol goes out a fixed number of cycles after the last transition. After that, refreshes repeat at a second, longer spacing until the input moves again. Each refresh carries the present level on a companion bit.

An input-side power-good signal gates the whole channel. While it is low, no symbols are sent and input changes are dropped. When it returns, one refresh is sent at once so the far side gets back in step.

Top module: `edgetx_channel`

## Requirements
- R1: A change of `dataIn` produces its symbol on `linkSym` exactly SYNC_STAGES+1 clock edges after the change is sampled. With the default of 2, a change driven between edges appears after the third following edge.
- R2: A low-to-high transition sends code 01 with `linkLevel` 1. A high-to-low transition sends code 10 with `linkLevel` 0. Each symbol lasts one cycle, so two transitions two cycles apart give two separate symbols two cycles apart.
- R3: While `refreshEn` is low and `dataIn` is static, `linkSym` stays at code 00 (idle).
- R4: With `refreshEn` high, if no transition occurs, a level refresh (code 11, `linkLevel` = current synchronised input) is sent IDLE_CYCLES cycles after the last edge symbol.
- R5: After a refresh, and while the input stays static, further refreshes follow every REFRESH_CYCLES cycles.
- R6: Any edge symbol restarts the watchdog, so the next refresh comes IDLE_CYCLES cycles after that edge.
- R7: While `powerGood` is low, `linkSym` stays 00 and `linkLevel` holds, whatever `dataIn` and `refreshEn` do.
- R8: On the first cycle that `powerGood` is sampled high after being low (including the first cycle after reset), a refresh (code 11) carrying the current level is sent on the next edge, whatever the state of `refreshEn`.
- R9: During and right after reset, `linkSym` is 00 and `linkLevel` is 0.
- R10: `linkLevel` changes only in a cycle that carries a non-idle symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dataIn | input | 1 | Asynchronous data input to be sent |
| refreshEn | input | 1 | Enables the inactivity watchdog and periodic level refresh |
| powerGood | input | 1 | Input-side supply good, synchronous to `clk` |
| linkSym | output | 2 | Symbol: 00 idle, 01 rise, 10 fall, 11 level refresh |
| linkLevel | output | 1 | Level carried by the latest symbol |

## Verification
The assertions assume that `powerGood` and `refreshEn` are already synchronous to `clk`, and that `dataIn` is held low through reset so that the first sampled level matches the reset state. The stimulus changes every input only on falling clock edges and always keeps `dataIn` low during reset. Input pulses in the stimulus are never narrower than two clock cycles, which matches the minimum input pulse width the channel is meant to carry.

// File: rtl/edgetx_pkg.sv
package edgetx_pkg;

  typedef enum logic [1:0] {
    SYM_IDLE  = 2'b00,
    SYM_RISE  = 2'b01,
    SYM_FALL  = 2'b10,
    SYM_LEVEL = 2'b11
  } sym_e;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    sym_e emit;         // symbol to register onto the link
    logic loadOut;      // capture symbol and level into output regs
    logic clearCnt;     // restart the idle watchdog
    logic countEn;      // advance the idle watchdog
    logic markRefresh;  // next window uses the refresh spacing
    logic clearRefresh; // next window uses the first-idle spacing
  } strobe_t;

endpackage

// File: rtl/edgetx_datapath.sv
module edgetx_datapath
  import edgetx_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int IDLE_CYCLES    = 20000,
  parameter int REFRESH_CYCLES = 40000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dataIn,
  input  strobe_t    strobe,
  output logic       riseSeen,
  output logic       fallSeen,
  output logic       reached,
  output logic [1:0] linkSym,
  output logic       linkLevel
);

  localparam int MAX_GAP = (IDLE_CYCLES > REFRESH_CYCLES) ? IDLE_CYCLES : REFRESH_CYCLES;
  localparam int CNT_W   = $clog2(MAX_GAP + 1);
  localparam logic [CNT_W-1:0] IDLE_LAST    = CNT_W'(IDLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] REFRESH_LAST = CNT_W'(REFRESH_CYCLES - 1);

  logic curLevel;
  logic prevLevel;
  logic [CNT_W-1:0] idleCnt;
  logic afterRefresh;
  sym_e symReg;
  logic levelReg;

  // Input synchroniser, depth chosen by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      logic syncOne;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncOne <= 1'b0;
        else       syncOne <= dataIn;
      end
      assign curLevel = syncOne;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] syncChain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], dataIn};
      end
      assign curLevel = syncChain[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= curLevel;
  end

  assign riseSeen = curLevel & ~prevLevel;
  assign fallSeen = ~curLevel & prevLevel;

  // Idle watchdog
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (strobe.clearCnt) begin
      idleCnt <= '0;
    end else if (strobe.countEn && !reached) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    afterRefresh <= 1'b0;
    else if (strobe.markRefresh)  afterRefresh <= 1'b1;
    else if (strobe.clearRefresh) afterRefresh <= 1'b0;
  end

  assign reached = afterRefresh ? (idleCnt >= REFRESH_LAST) : (idleCnt >= IDLE_LAST);

  // Link output registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      symReg   <= SYM_IDLE;
      levelReg <= 1'b0;
    end else begin
      symReg <= strobe.emit;
      if (strobe.loadOut) levelReg <= curLevel;
    end
  end

  assign linkSym   = symReg;
  assign linkLevel = levelReg;

endmodule

// File: rtl/edgetx_control.sv
module edgetx_control
  import edgetx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    powerGood,
  input  logic    refreshEn,
  input  logic    riseSeen,
  input  logic    fallSeen,
  input  logic    reached,
  output strobe_t strobe
);

  logic pgPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pgPrev <= 1'b0;
    else       pgPrev <= powerGood;
  end

  // Priority: power gate, wake refresh, edges, watchdog refresh
  always_comb begin
    strobe = '{emit: SYM_IDLE, loadOut: 1'b0, clearCnt: 1'b0,
               countEn: 1'b0, markRefresh: 1'b0, clearRefresh: 1'b0};
    if (!powerGood) begin
      strobe.clearCnt = 1'b1;
    end else if (!pgPrev) begin
      strobe.emit        = SYM_LEVEL;
      strobe.loadOut     = 1'b1;
      strobe.clearCnt    = 1'b1;
      strobe.markRefresh = 1'b1;
    end else if (riseSeen || fallSeen) begin
      strobe.emit         = riseSeen ? SYM_RISE : SYM_FALL;
      strobe.loadOut      = 1'b1;
      strobe.clearCnt     = 1'b1;
      strobe.clearRefresh = 1'b1;
    end else if (refreshEn && reached) begin
      strobe.emit        = SYM_LEVEL;
      strobe.loadOut     = 1'b1;
      strobe.clearCnt    = 1'b1;
      strobe.markRefresh = 1'b1;
    end else if (refreshEn) begin
      strobe.countEn = 1'b1;
    end else begin
      strobe.clearCnt = 1'b1;
    end
  end

endmodule

// File: rtl/edgetx_channel.sv
module edgetx_channel
  import edgetx_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int IDLE_CYCLES    = 20000,
  parameter int REFRESH_CYCLES = 40000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dataIn,
  input  logic       refreshEn,
  input  logic       powerGood,
  output logic [1:0] linkSym,
  output logic       linkLevel
);

  strobe_t strobe;
  logic riseSeen;
  logic fallSeen;
  logic reached;

  edgetx_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .powerGood (powerGood),
    .refreshEn (refreshEn),
    .riseSeen  (riseSeen),
    .fallSeen  (fallSeen),
    .reached   (reached),
    .strobe    (strobe)
  );

  edgetx_datapath #(
    .SYNC_STAGES    (SYNC_STAGES),
    .IDLE_CYCLES    (IDLE_CYCLES),
    .REFRESH_CYCLES (REFRESH_CYCLES)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .dataIn    (dataIn),
    .strobe    (strobe),
    .riseSeen  (riseSeen),
    .fallSeen  (fallSeen),
    .reached   (reached),
    .linkSym   (linkSym),
    .linkLevel (linkLevel)
  );

endmodule

// File: rtl/edgetx_channel_checker.sv
module edgetx_channel_checker #(
  parameter int IDLE_CYCLES    = 20000,
  parameter int REFRESH_CYCLES = 40000
) (
  input logic       clk,
  input logic       rstN,
  input logic       refreshEn,
  input logic       powerGood,
  input logic [1:0] linkSym,
  input logic       linkLevel
);

  localparam int MAX_GAP = (IDLE_CYCLES > REFRESH_CYCLES) ? IDLE_CYCLES : REFRESH_CYCLES;

  logic pgDly;
  int   gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pgDly <= 1'b0;
    else       pgDly <= powerGood;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                          gapCnt <= 0;
    else if (linkSym != 2'b00 || !refreshEn || !powerGood) gapCnt <= 0;
    else                                                gapCnt <= gapCnt + 1;
  end

  assert_pg_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !powerGood |=> (linkSym == 2'b00));

  assert_pg_wake_R8: assert property (@(posedge clk) disable iff (!rstN)
    (powerGood && !pgDly) |=> (linkSym == 2'b11));

  assert_rise_level_R2: assert property (@(posedge clk) disable iff (!rstN)
    (linkSym == 2'b01) |-> linkLevel);

  assert_fall_level_R2: assert property (@(posedge clk) disable iff (!rstN)
    (linkSym == 2'b10) |-> !linkLevel);

  assert_no_double_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    (linkSym == 2'b01) |=> (linkSym != 2'b01));

  assert_refresh_needs_enable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (linkSym == 2'b11) |-> ($past(refreshEn) || !$past(pgDly)));

  assert_level_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    (linkSym == 2'b00) |-> $stable(linkLevel));

  assert_gap_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    gapCnt <= MAX_GAP + 1);

endmodule

bind edgetx_channel edgetx_channel_checker #(
  .IDLE_CYCLES    (IDLE_CYCLES),
  .REFRESH_CYCLES (REFRESH_CYCLES)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .refreshEn (refreshEn),
  .powerGood (powerGood),
  .linkSym   (linkSym),
  .linkLevel (linkLevel)
);

// File: tb/edgetx_channel_bench.sv
module edgetx_channel_bench;

  localparam int SYNC    = 2;
  localparam int IDLE    = 12;
  localparam int REFRESH = 20;
  localparam int LAT     = SYNC + 1;

  logic clk = 1'b0;
  logic rstN;
  logic dataIn;
  logic refreshEn;
  logic powerGood;
  logic [1:0] linkSym;
  logic linkLevel;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  edgetx_channel #(
    .SYNC_STAGES    (SYNC),
    .IDLE_CYCLES    (IDLE),
    .REFRESH_CYCLES (REFRESH)
  ) u_edgetx_channel (
    .clk       (clk),
    .rstN      (rstN),
    .dataIn    (dataIn),
    .refreshEn (refreshEn),
    .powerGood (powerGood),
    .linkSym   (linkSym),
    .linkLevel (linkLevel)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  // Waits for the first non-idle symbol, up to maxc cycles
  task automatic observe(input int maxc, output int cyc,
                         output logic [1:0] s, output logic l);
    bit found = 0;
    cyc = 0; s = 2'b00; l = linkLevel;
    while (!found && cyc < maxc) begin
      @(posedge clk); @(negedge clk);
      cyc++;
      if (linkSym != 2'b00) begin
        found = 1; s = linkSym; l = linkLevel;
      end
    end
  endtask

  task automatic expectSym(input string req, input int maxc, input int expCyc,
                           input logic [1:0] expS, input logic expL);
    int c; logic [1:0] s; logic l;
    observe(maxc, c, s, l);
    check(c == expCyc, req, "symbol delay", c, expCyc);
    check(s == expS, req, "symbol code", int'(s), int'(expS));
    check(l == expL, req, "symbol level", int'(l), int'(expL));
  endtask

  task automatic expectQuiet(input string req, input int n);
    int c; logic [1:0] s; logic l;
    observe(n, c, s, l);
    check(s == 2'b00, req, "no symbol expected", int'(s), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic heldLevel;
    rstN = 1'b0; dataIn = 1'b0; refreshEn = 1'b0; powerGood = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(linkSym == 2'b00, "R9", "reset symbol", int'(linkSym), 0);
    check(linkLevel == 1'b0, "R9", "reset level", int'(linkLevel), 0);
    rstN = 1'b1;

    // R7: power down swallows input changes
    dataIn = 1'b1;
    expectQuiet("R7", 15);
    dataIn = 1'b0;
    expectQuiet("R7", 5);
    dataIn = 1'b1;
    expectQuiet("R7", 10);
    check(linkLevel == 1'b0, "R7", "level held while down", int'(linkLevel), 0);

    // R8: wake refresh with current level, refresh disabled
    powerGood = 1'b1;
    expectSym("R8", 5, 1, 2'b11, 1'b1);

    // R3: static input, refresh off; R10 level held
    expectQuiet("R3", 60);
    check(linkLevel == 1'b1, "R10", "level held while idle", int'(linkLevel), 1);

    // R1/R2: sweep of toggles with varied spacing
    for (int w = 2; w <= 9; w++) begin
      dataIn = ~dataIn;
      expectSym("R1", 10, LAT, dataIn ? 2'b01 : 2'b10, dataIn);
      repeat (w) @(negedge clk);
      check(linkSym == 2'b00, "R2", "one-cycle symbol", int'(linkSym), 0);
    end

    // R2: two edges two cycles apart
    dataIn = ~dataIn;
    fork
      begin repeat (2) @(negedge clk); dataIn = ~dataIn; end
      expectSym("R2", 10, LAT, dataIn ? 2'b01 : 2'b10, dataIn);
    join
    expectSym("R2", 10, 2, dataIn ? 2'b01 : 2'b10, dataIn);

    // R4/R5: watchdog refresh timing
    refreshEn = 1'b1;
    @(negedge clk);
    dataIn = ~dataIn;
    expectSym("R1", 10, LAT, dataIn ? 2'b01 : 2'b10, dataIn);
    expectSym("R4", 40, IDLE, 2'b11, dataIn);
    expectSym("R5", 40, REFRESH, 2'b11, dataIn);
    expectSym("R5", 40, REFRESH, 2'b11, dataIn);

    // R6: edge restarts the watchdog
    repeat (5) @(negedge clk);
    dataIn = ~dataIn;
    expectSym("R6", 10, LAT, dataIn ? 2'b01 : 2'b10, dataIn);
    expectSym("R6", 40, IDLE, 2'b11, dataIn);

    // R7 with refresh on, then R8 wake and R5 spacing resumes
    powerGood = 1'b0;
    heldLevel = linkLevel;
    fork
      begin repeat (7) @(negedge clk); dataIn = ~dataIn; end
      expectQuiet("R7", 50);
    join
    check(linkLevel == heldLevel, "R7", "level held while down",
          int'(linkLevel), int'(heldLevel));
    powerGood = 1'b1;
    expectSym("R8", 5, 1, 2'b11, dataIn);
    expectSym("R5", 40, REFRESH, 2'b11, dataIn);

    // R3: refresh disabled again
    refreshEn = 1'b0;
    expectQuiet("R3", 60);

    finishRun();
  end

endmodule